// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

The sequencer runs whole register transactions against a device with a 7-bit bus address. It sits on top of a separate bit-level bus engine and handles only the order of the transaction. It asks the engine for one primitive at a time: a START, a STOP, a byte write or a byte read. It then waits for the engine to report completion, along with the acknowledge it sampled and any byte it received. Bus timing stays inside the engine. The sequencer times only its own pauses, in clock cycles derived from a cycles-per-microsecond parameter.

A host pulses `req` with a transfer kind, a device address, a register index and a byte count. There are three transfer kinds:

- **Write:** addresses the device, sends the register index, then streams the data bytes.
- **Read:** addresses the device for writing and sends the register index. It then issues a STOP, addresses the device again for reading, and collects the bytes.
- **Poll:** repeatedly addresses the device until it acknowledges. This shows that an internal write cycle in the device has finished.

If the device ignores its address, the sequencer pauses and retries, up to a bounded number of attempts. Every transaction ends with a STOP and a one-cycle `done` pulse carrying a status code.

Top module: `i2c_xfer_seq`

## Requirements
- R1: The address byte sent to the engine is the device address in bits 7:1. Bit 0 is 0 for a write direction and 1 for a read direction. Write and poll transfers and the first phase of a read use direction 0. The second phase of a read uses direction 1.
- R2: An address phase is a START followed by the address byte. If the engine reports NACK, the sequencer waits RETRY_US×CLK_PER_US cycles and then issues a fresh START. After MAX_TRIES (default 10) failed attempts it issues a STOP and finishes with status 1. Measured from the cycle in which `eng_done` reports the NACK, the next START request is due exactly RETRY_US×CLK_PER_US+2 cycles later.
- R3: In a write, the register index follows an acknowledged address byte. A NACK on the register index causes a STOP and status 3.
- R4: In a write, `byte_cnt` data bytes follow the register index, taken in order from `wr_data`. `wr_take` pulses in the cycle each byte is handed to the engine. A NACK on any data byte causes a STOP and status 4, and no further bytes are sent.
- R5: A read sends the address with direction 0, then the register index, then a STOP. It then repeats the retried address phase with direction 1, and then issues `byte_cnt` byte-read commands.
- R6: In a read, each byte-read command carries `cmd_ack`=0, except the last one, which carries 1 (NACK). Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in arrival order.
- R7: In a read, a NACK on the register index, or exhaustion of the second address phase, causes a STOP and status 1.
- R8: A poll issues START and the address with direction 0. On NACK it issues STOP, waits POLL_US×CLK_PER_US cycles, and repeats, with no attempt limit. The next START is due exactly POLL_US×CLK_PER_US+2 cycles after the STOP completes. On ACK it issues a STOP and finishes with status 0.
- R9: A transaction that completes its last byte issues a STOP and reports status 0. `done` is a one-cycle pulse in the cycle after the final STOP completes. `status` is one of 0, 1, 3 or 4 while `done` is high.
- R10: Engine commands are single-cycle `cmd_go` pulses, and no new command is issued until `eng_done` answers the previous one. Command codes on `cmd_op`: 0 START, 1 STOP, 2 byte write, 3 byte read.
- R11: After reset, `cmd_go`, `done`, `rd_valid` and `wr_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a transaction; ignored while one is running |
| xfer_kind | input | 2 | 0 write, 1 read, 2 poll |
| dev_addr | input | 7 | Device bus address |
| reg_idx | input | 8 | Register index |
| byte_cnt | input | CNT_W | Number of data bytes |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Current `wr_data` consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| done | output | 1 | Transaction finished |
| status | output | 3 | Result code, valid with `done` |
| cmd_go | output | 1 | Engine command strobe |
| cmd_op | output | 2 | Engine command code |
| cmd_byte | output | 8 | Byte for a write command |
| cmd_ack | output | 1 | Acknowledge bit for a read command |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Engine saw NACK on a written byte |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
The bench models the engine and answers every command exactly three cycles after its strobe. The sequencer's next command therefore follows one register stage after that answer. `rd_valid` and `done` arrive in the cycle after the answering `eng_done`.

The pause checks measure the distance from the engine's NACK or STOP completion to the next START strobe and require the exact figure from R2 and R8. All outputs are sampled on the falling edge. Each strobe is compared against the head of an expected-command queue in the cycle it appears, and the status is compared in the single cycle `done` is high.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [1:0] {
      XF_WRITE = 2'd0,
      XF_READ  = 2'd1,
      XF_POLL  = 2'd2
   } xfer_e;

   typedef enum logic [1:0] {
      BUS_START = 2'd0,
      BUS_STOP  = 2'd1,
      BUS_WR    = 2'd2,
      BUS_RD    = 2'd3
   } bus_op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_ADDR, S_RWAIT, S_REG, S_MIDSTOP,
      S_WDATA, S_RDATA, S_PSTOP, S_PWAIT, S_STOP
   } seq_state_e;

   localparam logic [2:0] RES_OK      = 3'd0;
   localparam logic [2:0] RES_NOADDR  = 3'd1;
   localparam logic [2:0] RES_REGNAK  = 3'd3;
   localparam logic [2:0] RES_DATANAK = 3'd4;

endpackage

// File: rtl/i2cseq_cnt.sv
module i2cseq_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_zero,
   output logic         is_one
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (dec && !is_zero)    cnt_q <= cnt_q - 1'b1;
   end

   assign is_zero = (cnt_q == '0);
   assign is_one  = (cnt_q == W'(1));
endmodule

// File: rtl/i2cseq_wait.sv
module i2cseq_wait #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 left_q <= '0;
      else if (load)              left_q <= load_val;
      else if (left_q != '0)      left_q <= left_q - 1'b1;
   end

   assign expired = (left_q == '0);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2cseq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int CLK_PER_US = 100,
   parameter int RETRY_US   = 600,
   parameter int POLL_US    = 50,
   parameter int MAX_TRIES  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [1:0]       xfer_kind,
   input  logic [6:0]       dev_addr,
   input  logic [7:0]       reg_idx,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [7:0]       wr_data,
   output logic             wr_take,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             done,
   output logic [2:0]       status,
   output logic             cmd_go,
   output logic [1:0]       cmd_op,
   output logic [7:0]       cmd_byte,
   output logic             cmd_ack,
   input  logic             eng_done,
   input  logic             eng_nack,
   input  logic [7:0]       eng_rdata
);
   localparam int RETRY_TICKS = RETRY_US * CLK_PER_US;
   localparam int POLL_TICKS  = POLL_US * CLK_PER_US;
   localparam int TMR_MAX     = (RETRY_TICKS > POLL_TICKS) ? RETRY_TICKS : POLL_TICKS;
   localparam int TMR_W       = $clog2(TMR_MAX + 1);
   localparam int TRY_W       = $clog2(MAX_TRIES + 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (TMR_MAX < 1) begin : g_bad_tmr
         $error("pause lengths must be nonzero");
      end
   endgenerate

   seq_state_e state_q, state_d;
   xfer_e      kind_q;
   logic [6:0] addr_q;
   logic [7:0] reg_q;
   logic       pend_q;
   logic       addr_rd_q, addr_rd_d;
   logic [2:0] status_q, status_d;
   logic       done_q, rdv_q;
   logic [7:0] rdat_q;

   logic             issue, fin;
   logic             byte_load, byte_dec, bytes_zero, bytes_one;
   logic             try_load, try_dec, tries_zero, tries_one;
   logic             tmr_load, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   logic             rd_push;

   i2cseq_cnt #(.W(CNT_W)) u_bytes (
      .clk(clk), .rst_n(rst_n), .load(byte_load), .load_val(byte_cnt),
      .dec(byte_dec), .is_zero(bytes_zero), .is_one(bytes_one)
   );

   i2cseq_cnt #(.W(TRY_W)) u_tries (
      .clk(clk), .rst_n(rst_n), .load(try_load), .load_val(TRY_W'(MAX_TRIES)),
      .dec(try_dec), .is_zero(tries_zero), .is_one(tries_one)
   );

   i2cseq_wait #(.W(TMR_W)) u_pause (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_exp)
   );

   // Command presentation
   always_comb begin
      issue = 1'b0;
      cmd_op = BUS_STOP;
      cmd_byte = 8'h00;
      case (state_q)
         S_START:   begin issue = 1'b1; cmd_op = BUS_START; end
         S_ADDR:    begin issue = 1'b1; cmd_op = BUS_WR; cmd_byte = {addr_q, addr_rd_q}; end
         S_REG:     begin issue = 1'b1; cmd_op = BUS_WR; cmd_byte = reg_q; end
         S_WDATA:   begin issue = 1'b1; cmd_op = BUS_WR; cmd_byte = wr_data; end
         S_RDATA:   begin issue = 1'b1; cmd_op = BUS_RD; end
         S_MIDSTOP,
         S_PSTOP,
         S_STOP:    begin issue = 1'b1; cmd_op = BUS_STOP; end
         default:   ;
      endcase
   end

   assign cmd_go  = issue && !pend_q;
   assign cmd_ack = (state_q == S_RDATA) && bytes_one;
   assign wr_take = cmd_go && (state_q == S_WDATA);
   assign fin     = pend_q && eng_done;

   // Sequencing
   always_comb begin
      state_d   = state_q;
      status_d  = status_q;
      addr_rd_d = addr_rd_q;
      byte_load = 1'b0;
      byte_dec  = 1'b0;
      try_load  = 1'b0;
      try_dec   = 1'b0;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      rd_push   = 1'b0;
      case (state_q)
         S_IDLE: if (req) begin
            state_d   = S_START;
            status_d  = RES_OK;
            addr_rd_d = 1'b0;
            byte_load = 1'b1;
            try_load  = 1'b1;
         end
         S_START: if (fin) state_d = S_ADDR;
         S_ADDR: if (fin) begin
            if (!eng_nack) begin
               if (kind_q == XF_POLL)  state_d = S_STOP;
               else if (addr_rd_q)     state_d = bytes_zero ? S_STOP : S_RDATA;
               else                    state_d = S_REG;
            end else if (kind_q == XF_POLL) begin
               state_d = S_PSTOP;
            end else if (tries_one || tries_zero) begin
               status_d = RES_NOADDR;
               state_d  = S_STOP;
            end else begin
               try_dec  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(RETRY_TICKS);
               state_d  = S_RWAIT;
            end
         end
         S_RWAIT: if (tmr_exp) state_d = S_START;
         S_REG: if (fin) begin
            if (eng_nack) begin
               status_d = (kind_q == XF_READ) ? RES_NOADDR : RES_REGNAK;
               state_d  = S_STOP;
            end else if (kind_q == XF_READ) begin
               state_d = S_MIDSTOP;
            end else begin
               state_d = bytes_zero ? S_STOP : S_WDATA;
            end
         end
         S_MIDSTOP: if (fin) begin
            addr_rd_d = 1'b1;
            try_load  = 1'b1;
            state_d   = S_START;
         end
         S_WDATA: if (fin) begin
            if (eng_nack) begin
               status_d = RES_DATANAK;
               state_d  = S_STOP;
            end else begin
               byte_dec = 1'b1;
               if (bytes_one) state_d = S_STOP;
            end
         end
         S_RDATA: if (fin) begin
            rd_push  = 1'b1;
            byte_dec = 1'b1;
            if (bytes_one) state_d = S_STOP;
         end
         S_PSTOP: if (fin) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_TICKS);
            state_d  = S_PWAIT;
         end
         S_PWAIT: if (tmr_exp) state_d = S_START;
         S_STOP: if (fin) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         kind_q    <= XF_WRITE;
         addr_q    <= '0;
         reg_q     <= '0;
         pend_q    <= 1'b0;
         addr_rd_q <= 1'b0;
         status_q  <= RES_OK;
         done_q    <= 1'b0;
         rdv_q     <= 1'b0;
         rdat_q    <= '0;
      end else begin
         state_q   <= state_d;
         addr_rd_q <= addr_rd_d;
         status_q  <= status_d;
         if (cmd_go)   pend_q <= 1'b1;
         else if (fin) pend_q <= 1'b0;
         if (state_q == S_IDLE && req) begin
            kind_q <= xfer_e'(xfer_kind);
            addr_q <= dev_addr;
            reg_q  <= reg_idx;
         end
         done_q <= (state_q == S_STOP) && fin;
         rdv_q  <= rd_push;
         if (rd_push) rdat_q <= eng_rdata;
      end
   end

   assign done     = done_q;
   assign status   = status_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdat_q;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_go,
   input logic [1:0] cmd_op,
   input logic       cmd_ack,
   input logic       eng_done,
   input logic       done,
   input logic [2:0] status,
   input logic       wr_take,
   input logic       rd_valid
);
   assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> !cmd_go);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_follows_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(eng_done));

   assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status == 3'd0 || status == 3'd1 || status == 3'd3 || status == 3'd4));

   assert_take_is_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> (cmd_go && cmd_op == 2'd2));

   assert_rdvalid_after_engine_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(eng_done));

   assert_nack_only_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_ack) |-> (cmd_op == 2'd3));
endmodule

bind i2c_xfer_seq i2cseq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_ack(cmd_ack),
   .eng_done(eng_done), .done(done), .status(status), .wr_take(wr_take),
   .rd_valid(rd_valid)
);

// File: tb/test_i2c_xfer_seq.sv
module test_i2c_xfer_seq;
   localparam int CLK_PERIOD = 10;
   localparam int US         = 1;
   localparam int RETRY      = 600 * US;
   localparam int POLL       = 50 * US;
   localparam logic [6:0] DEV = 7'h50;
   localparam logic [7:0] REG = 8'h12;

   logic       clk = 1'b0, rst_n = 1'b0, req = 1'b0;
   logic [1:0] xfer_kind = 2'd0;
   logic [7:0] byte_cnt = 8'd0, wr_data = 8'h30;
   logic       wr_take, rd_valid, done, cmd_go, cmd_ack;
   logic [7:0] rd_data, cmd_byte;
   logic [2:0] status;
   logic [1:0] cmd_op;
   logic       eng_done = 1'b0, eng_nack = 1'b0;
   logic [7:0] eng_rdata = 8'h00;

   i2c_xfer_seq #(.CLK_PER_US(US)) i_i2c_xfer_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .xfer_kind(xfer_kind), .dev_addr(DEV),
      .reg_idx(REG), .byte_cnt(byte_cnt), .wr_data(wr_data), .wr_take(wr_take),
      .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .status(status),
      .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
      .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [10:0] exp_cmd[$];
   logic [7:0]  exp_rd[$];
   logic [10:0] e;
   logic [7:0]  er;
   int nk_from, nk_to, dnak, wr_idx;
   bit rnak, poll_mode, done_seen;
   logic [2:0] exp_st;
   string tag = "R11";

   // engine model state
   int m_lat = 0, wcnt = 0, aidx = 0, ridx = 0, last_kind = 0, last_done_cyc = 0, r_kind = 0;
   bit r_nack = 1'b0;
   logic [7:0] r_data = 8'h00;

   task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   // Engine model: answers each command three falling edges after its strobe
   always @(negedge clk) begin
      eng_done = 1'b0;
      if (m_lat > 0) begin
         m_lat--;
         if (m_lat == 0) begin
            eng_done = 1'b1; eng_nack = r_nack; eng_rdata = r_data;
            last_kind = r_kind; last_done_cyc = cyc;
         end
      end
      if (cmd_go) begin
         m_lat = 3; r_nack = 1'b0; r_kind = 0;
         case (cmd_op)
            2'd0: wcnt = 0;
            2'd1: r_kind = 2;
            2'd2: begin
               if (wcnt == 0) begin
                  r_nack = (aidx >= nk_from && aidx < nk_to);
                  if (r_nack) r_kind = 1;
                  aidx++;
               end else if (wcnt == 1) r_nack = rnak;
               else r_nack = (wcnt - 2 == dnak);
               wcnt++;
            end
            default: begin r_data = 8'hA0 + 8'(ridx); ridx++; end
         endcase
      end
   end

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (cmd_go) begin
         if (exp_cmd.size() == 0) check(1'b0, tag, "unexpected command", int'(cmd_op), 0);
         else begin
            e = exp_cmd.pop_front();
            check(cmd_op == e[10:9], tag, "command code", int'(cmd_op), int'(e[10:9]));
            if (e[10:9] == 2'd2) check(cmd_byte == e[8:1], tag, "written byte (R1)", int'(cmd_byte), int'(e[8:1]));
            if (e[10:9] == 2'd3) check(cmd_ack == e[0], "R6", "read ack bit", int'(cmd_ack), int'(e[0]));
         end
         if (cmd_op == 2'd0 && last_kind == 1)
            check(cyc - last_done_cyc == RETRY + 2, "R2", "retry pause", cyc - last_done_cyc, RETRY + 2);
         if (cmd_op == 2'd0 && last_kind == 2 && poll_mode)
            check(cyc - last_done_cyc == POLL + 2, "R8", "poll pause", cyc - last_done_cyc, POLL + 2);
         if (cmd_op == 2'd0) last_kind = 0;
         if (wr_take) begin wr_idx++; wr_data = 8'h30 + 8'(wr_idx); end
      end
      if (rd_valid) begin
         if (exp_rd.size() == 0) check(1'b0, "R6", "unexpected read byte", int'(rd_data), 0);
         else begin
            er = exp_rd.pop_front();
            check(rd_data == er, "R6", "read byte", int'(rd_data), int'(er));
         end
      end
      if (done) begin
         check(status == exp_st, tag, "status", int'(status), int'(exp_st));
         check(exp_cmd.size() == 0, tag, "missing commands", exp_cmd.size(), 0);
         done_seen = 1'b1;
      end
   end

   task automatic push(input logic [1:0] op, input logic [7:0] b, input logic a);
      exp_cmd.push_back({op, b, a});
   endtask

   task automatic addr_phase(input bit dir, inout int idx, output bit ok);
      ok = 1'b0;
      for (int t = 0; t < 10; t++) begin
         push(2'd0, 8'h00, 1'b0);
         push(2'd2, {DEV, dir}, 1'b0);
         if (!(idx >= nk_from && idx < nk_to)) begin idx++; ok = 1'b1; return; end
         idx++;
      end
   endtask

   task automatic run(input int xop, input int n, input int nf, input int nt, input bit rn,
                      input int dn, input logic [2:0] st, input string t);
      int idx = 0;
      bit ok;
      tag = t; nk_from = nf; nk_to = nt; rnak = rn; dnak = dn; exp_st = st;
      poll_mode = (xop == 2); aidx = 0; wcnt = 0; ridx = 0; wr_idx = 0;
      wr_data = 8'h30; last_kind = 0; done_seen = 1'b0;
      if (xop == 2) begin
         forever begin
            push(2'd0, 8'h00, 1'b0);
            push(2'd2, {DEV, 1'b0}, 1'b0);
            push(2'd1, 8'h00, 1'b0);
            if (!(idx >= nf && idx < nt)) break;
            idx++;
         end
      end else begin
         addr_phase(1'b0, idx, ok);
         if (ok) begin
            push(2'd2, REG, 1'b0);
            if (!rn && xop == 0) begin
               for (int i = 0; i < n; i++) begin
                  push(2'd2, 8'h30 + 8'(i), 1'b0);
                  if (i == dn) break;
               end
            end else if (!rn) begin
               push(2'd1, 8'h00, 1'b0);
               addr_phase(1'b1, idx, ok);
               if (ok) for (int i = 0; i < n; i++) begin
                  push(2'd3, 8'h00, (i == n - 1));
                  exp_rd.push_back(8'hA0 + 8'(i));
               end
            end
         end
         push(2'd1, 8'h00, 1'b0);
      end
      @(negedge clk);
      xfer_kind = 2'(xop); byte_cnt = 8'(n); req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait (done_seen);
      @(negedge clk);
      check(exp_rd.size() == 0, t, "missing read bytes", exp_rd.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cmd_go && !done && !rd_valid && !wr_take, "R11", "idle outputs after reset",
            {cmd_go, done, rd_valid, wr_take}, 0);
      run(0, 2, 0, 0,  1'b0, -1, 3'd0, "R1 R4 R9 write");
      run(0, 1, 0, 2,  1'b0, -1, 3'd0, "R2 write retried");
      run(0, 1, 0, 99, 1'b0, -1, 3'd1, "R2 address exhausted");
      run(0, 2, 0, 0,  1'b1, -1, 3'd3, "R3 register nack");
      run(0, 3, 0, 0,  1'b0, 1,  3'd4, "R4 data nack");
      run(1, 3, 0, 0,  1'b0, -1, 3'd0, "R5 read");
      run(1, 1, 1, 3,  1'b0, -1, 3'd0, "R5 read second phase retried");
      run(1, 2, 0, 0,  1'b1, -1, 3'd1, "R7 read register nack");
      run(1, 2, 1, 99, 1'b0, -1, 3'd1, "R7 read second address exhausted");
      run(2, 0, 0, 2,  1'b0, -1, 3'd0, "R8 poll");
      run(2, 0, 0, 0,  1'b0, -1, 3'd0, "R8 poll immediate");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule